// File: doc/BRIEF.md
# Complementary PWM Timer with Deadband

This block is a 16-bit up-counting timer that drives a PWM waveform on one output and its complement on a second output. The count advances once every 1, 2, 4 … 128 system clock cycles and runs from 1 up to a programmable reload value. A compare against a programmable match value inverts the primary waveform partway through each period. At the end of each period the count restarts at 1, the waveform returns to its start level, and a one-cycle interrupt pulse is raised.

A programmable deadband of 0 to 128 clock cycles holds back every rising edge on both outputs. Falling edges are not delayed, so the two outputs are never high together. A small write-only register port sets the enable, polarity, prescale, match, reload and deadband values. All of them except the enable bit are locked while the timer runs. Typical use: disable, program, enable, and service the interrupt once per period.

Top module: `pwm_pair_timer`

## Requirements
- R1: In reset `pwm_out`, `pwm_out_n` and `irq` are 0. Reset leaves the timer disabled with polarity 0, prescale select 0, match 0x0000, reload 0xFFFF and deadband 0.
- R2: Writes use `cfg_addr` 0 for control (bit 0 enable, bit 1 polarity, bits 4:2 prescale select), 1 for match, 2 for reload and 3 for deadband (bits 7:0). While the timer is enabled, writes to addresses 1 to 3 and to control bits 4:2 and 1 are ignored.
- R3: The write that sets the enable bit is edge W. After edge W the count is 1 and the primary level equals the polarity bit.
- R4: With prescale select s, the count advances on edges W+k·2^s only (k ≥ 1).
- R5: On an advance where the count equals the match value, the primary level inverts and counting continues.
- R6: On an advance where the count equals the reload value, the count returns to 1 and the primary level returns to the polarity value. `irq` is high for the following cycle.
- R7: A match value of 0, or a match value at or above the reload value, produces no inversion. The primary level stays at the polarity value for the whole period.
- R8: `pwm_out_n` follows the complement of the primary level, under the same deadband rule.
- R9: With deadband D, each output is 1 after an edge exactly when its underlying level was 1 on the previous D+1 cycles. A fall therefore shows one cycle after the level falls, and a rise shows D+1 cycles after the level rises.
- R10: A rise whose underlying level drops back before its D+1 cycles have elapsed never appears on the output.
- R11: A deadband write above 128 stores 128.
- R12: `pwm_out` and `pwm_out_n` are never both 1.
- R13: Clearing the enable bit stops counting and resets the count to 1. The primary level returns to the polarity value and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| pwm_out | output | 1 | Primary PWM output after deadband |
| pwm_out_n | output | 1 | Complementary PWM output after deadband |
| irq | output | 1 | One-cycle pulse at each period end |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 3-bit prescale select and a deadband ceiling of 128. It then sweeps small reload values (1 to 5) against match values from 0 to 6, across three prescale settings, both polarities and several deadbands. Short periods bring every match/reload relation into view within a few hundred cycles: match 0, match inside the period, match equal to reload and match above it, along with high pulses shorter than the deadband. The full ceiling is reached with a long period and a clamped deadband write. Writes made while running are injected in the middle of a run.

// File: rtl/pwm_pair_pkg.sv
// Package: shared register selects and control field layout for the
// complementary PWM timer. Assumes a 2-bit register address.
package pwm_pair_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_MATCH  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_DBAND  = 2'd3
    } reg_sel_e;

    // Control word bit positions (bit 0 enable, bit 1 polarity, 4:2 prescale)
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_POL_BIT  = 1;
    localparam int CTRL_PSEL_LSB = 2;
endpackage

// File: rtl/pwm_cfg_regs.sv
// Module: configuration register file. Holds enable, polarity, prescale
// select, match, reload and deadband. Assumes writes are single-cycle
// strobes; everything but the enable bit is locked while enabled, and
// deadband values above DB_MAX are clamped.
module pwm_cfg_regs
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSEL_W = 3,
    parameter int DB_MAX = 128,
    localparam int DB_W  = $clog2(DB_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic              en,
    output logic              pol,
    output logic [PSEL_W-1:0] psel,
    output logic [CNT_W-1:0]  match,
    output logic [CNT_W-1:0]  reload,
    output logic [DB_W-1:0]   dband
);
    logic [DB_W-1:0] db_field;
    logic [DB_W-1:0] db_clamped;

    // Purpose: clamp the incoming deadband field to the ceiling.
    always_comb begin
        db_field   = wdata[DB_W-1:0];
        db_clamped = (db_field > DB_W'(DB_MAX)) ? DB_W'(DB_MAX) : db_field;
    end

    // Purpose: capture register writes, honouring the run-time lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            pol    <= 1'b0;
            psel   <= '0;
            match  <= '0;
            reload <= '1;
            dband  <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                REG_CTRL: begin
                    en <= wdata[CTRL_EN_BIT];
                    if (!en) begin
                        pol  <= wdata[CTRL_POL_BIT];
                        psel <= wdata[CTRL_PSEL_LSB +: PSEL_W];
                    end
                end
                REG_MATCH:  if (!en) match  <= wdata;
                REG_RELOAD: if (!en) reload <= wdata;
                REG_DBAND:  if (!en) dband  <= db_clamped;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Module: power-of-two prescaler. Produces a one-cycle tick every
// 2^psel enabled cycles. Assumes psel is stable while enabled; the
// divider restarts from zero whenever the timer is disabled.
module pwm_prescaler #(
    parameter int PSEL_W = 3,
    localparam int DIV_W = (1 << PSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Purpose: build a mask of psel low ones selecting the divide.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(psel));
        end
    end

    // Purpose: free-running divide counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = en && ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_period_core.sv
// Module: period counter and compare logic. Counts 1..reload on each
// tick, inverts the primary level at the match count, restarts at 1 and
// pulses the interrupt at reload. Assumes match/reload/pol are frozen
// while enabled. The primary level is the polarity XOR a toggle flag.
module pwm_period_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic             tick,
    input  logic [CNT_W-1:0] match,
    input  logic [CNT_W-1:0] reload,
    output logic             raw_lvl,
    output logic             irq,
    output logic [CNT_W-1:0] cnt
);
    logic inv_q;
    logic match_ok;
    logic at_reload;
    logic at_match;

    // Purpose: decode compare events for the current count.
    always_comb begin
        match_ok  = (match < reload);
        at_reload = (cnt == reload);
        at_match  = match_ok && (cnt == match);
    end

    // Purpose: advance the count and update toggle and interrupt state.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= CNT_W'(1);
            inv_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (tick) begin
                if (at_reload) begin
                    cnt   <= CNT_W'(1);
                    inv_q <= 1'b0;
                    irq   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (at_match) begin
                        inv_q <= ~inv_q;
                    end
                end
            end
        end
    end

    assign raw_lvl = pol ^ inv_q;
endmodule

// File: rtl/pwm_deadband.sv
// Module: rising-edge delay for one output. The output falls one cycle
// after its level falls, and rises once the level has been high for
// dly+1 consecutive cycles. Assumes dly never exceeds the counter range.
module pwm_deadband #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl,
    input  logic [DB_W-1:0] dly,
    output logic            q
);
    logic [DB_W-1:0] wait_q;

    // Purpose: count high cycles and release the output when done.
    always_ff @(posedge clk) begin
        if (!rst_n || !lvl) begin
            q      <= 1'b0;
            wait_q <= '0;
        end else if (!q) begin
            if (wait_q >= dly) begin
                q <= 1'b1;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_pair_timer.sv
// Module: top of the complementary PWM timer. Ties together the register
// file, the prescaler, the period core and one deadband stage per output.
// Assumes a synchronous active-low reset and single-cycle write strobes.
module pwm_pair_timer
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSEL_W = 3,
    parameter int DB_MAX = 128,
    localparam int DB_W  = $clog2(DB_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic              pwm_out,
    output logic              pwm_out_n,
    output logic              irq
);
    logic              cfg_en;
    logic              cfg_pol;
    logic [PSEL_W-1:0] cfg_psel;
    logic [CNT_W-1:0]  cfg_match;
    logic [CNT_W-1:0]  cfg_reload;
    logic [DB_W-1:0]   cfg_dband;
    logic              tick;
    logic              raw_lvl;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        lvl_v;
    logic [1:0]        q_v;

    pwm_cfg_regs #(
        .CNT_W (CNT_W),
        .PSEL_W(PSEL_W),
        .DB_MAX(DB_MAX)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .en    (cfg_en),
        .pol   (cfg_pol),
        .psel  (cfg_psel),
        .match (cfg_match),
        .reload(cfg_reload),
        .dband (cfg_dband)
    );

    pwm_prescaler #(
        .PSEL_W(PSEL_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_en),
        .psel (cfg_psel),
        .tick (tick)
    );

    pwm_period_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_en),
        .pol    (cfg_pol),
        .tick   (tick),
        .match  (cfg_match),
        .reload (cfg_reload),
        .raw_lvl(raw_lvl),
        .irq    (irq),
        .cnt    (cnt_q)
    );

    // Channel 0 follows the primary level, channel 1 its complement.
    assign lvl_v = {~raw_lvl, raw_lvl};

    for (genvar ch = 0; ch < 2; ch++) begin : g_db
        pwm_deadband #(
            .DB_W(DB_W)
        ) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_v[ch]),
            .dly  (cfg_dband),
            .q    (q_v[ch])
        );
    end

    assign pwm_out   = q_v[0];
    assign pwm_out_n = q_v[1];
endmodule

// File: rtl/pwm_pair_timer_chk.sv
// Module: assertion checker for the complementary PWM timer, bound into
// every instance of the top module.
module pwm_pair_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             pwm_out_n,
    input logic             irq,
    input logic             en,
    input logic             raw,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] match,
    input logic [CNT_W-1:0] reload
);
    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_out && pwm_out_n));

    // R6
    irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));

    // R6
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && reload != '0) |-> (cnt >= CNT_W'(1) && cnt <= reload));

    // R2
    match_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(match));

    // R2
    reload_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(reload));

    // R13
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == CNT_W'(1)));

    // R9
    rise_after_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(raw));

    // R9
    comp_fall_after_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out_n) |-> $past(raw));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_out  (pwm_out),
    .pwm_out_n(pwm_out_n),
    .irq      (irq),
    .en       (cfg_en),
    .raw      (raw_lvl),
    .cnt      (cnt_q),
    .match    (cfg_match),
    .reload   (cfg_reload)
);

// File: tb/sim_pwm_pair_timer.sv
`timescale 1ns/1ps
module sim_pwm_pair_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        pwm_out;
    logic        pwm_out_n;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    // expected-model settings of the current run
    int e_p = 1;
    int e_r = 1;
    int e_m = 0;
    int e_d = 0;
    bit e_pol = 1'b0;

    pwm_pair_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .pwm_out  (pwm_out),
        .pwm_out_n(pwm_out_n),
        .irq      (irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d (p=%0d r=%0d m=%0d d=%0d pol=%0d)",
                     tag, got, exp, e_p, e_r, e_m, e_d, e_pol);
        end
    endtask

    // one write; called and returning at a falling edge
    task automatic wr(input int a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(a);
        cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // primary level after edge W+m
    function automatic bit raw_at(input int m);
        int k, pos;
        bit inv;
        if (m < 0) return e_pol;
        k   = m / e_p;
        pos = k % e_r;
        inv = (e_m >= 1) && (e_m < e_r) && (pos >= e_m);
        return e_pol ^ inv;
    endfunction

    // deadbanded output after edge W+n
    function automatic bit db_at(input int n, input bit comp);
        for (int j = 0; j <= e_d; j++) begin
            if ((raw_at(n - 1 - j) ^ comp) == 1'b0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic run_cfg(input bit pol, input int sel, input int r, input int m,
                           input int dwr, input int ncyc, input bit inject,
                           input string tag);
        e_pol = pol;
        e_p   = 1 << sel;
        e_r   = r;
        e_m   = m;
        e_d   = (dwr > 128) ? 128 : dwr;
        wr(0, (sel << 2) | (int'(pol) << 1));
        wr(1, m);
        wr(2, r);
        wr(3, dwr);
        repeat (e_d + 4) @(negedge clk);
        wr(0, (sel << 2) | (int'(pol) << 1) | 1);   // edge W
        for (int n = 0; n <= ncyc; n++) begin
            cfg_we = 1'b0;
            chk({tag, " R3 R4 R5 R7 R9 R10 pwm_out"}, int'(pwm_out), int'(db_at(n, 1'b0)));
            chk({tag, " R8 R9 R10 pwm_out_n"}, int'(pwm_out_n), int'(db_at(n, 1'b1)));
            chk({tag, " R6 irq"}, int'(irq),
                int'(n >= 1 && (n % e_p) == 0 && ((n / e_p) % e_r) == 0));
            chk({tag, " R12 overlap"}, int'(pwm_out && pwm_out_n), 0);
            if (inject) begin
                // R2: these writes land while enabled and must be ignored
                if (n == 4) begin cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 16'd1; end
                if (n == 5) begin cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 16'd2; end
                if (n == 6) begin cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'd0; end
                if (n == 7) begin
                    cfg_we = 1'b1; cfg_addr = 2'd0;
                    cfg_wdata = 16'((2 << 2) | (int'(~pol) << 1) | 1);
                end
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        // R13: disable, outputs settle at the polarity start level
        wr(0, (sel << 2) | (int'(pol) << 1));
        repeat (e_d + 3) @(negedge clk);
        chk("R13 idle pwm_out", int'(pwm_out), int'(pol));
        chk("R13 idle pwm_out_n", int'(pwm_out_n), int'(!pol));
        repeat (10) @(negedge clk);
        chk("R13 idle irq", int'(irq), 0);
        chk("R13 idle held", int'(pwm_out), int'(pol));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: everything low while in reset
        chk("R1 reset pwm_out", int'(pwm_out), 0);
        chk("R1 reset pwm_out_n", int'(pwm_out_n), 0);
        chk("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: defaults (match 0, reload 0xFFFF, pol 0) give a static run
        wr(0, 1);
        repeat (40) @(negedge clk);
        chk("R1 default pwm_out", int'(pwm_out), 0);
        chk("R1 default pwm_out_n", int'(pwm_out_n), 1);
        chk("R1 default irq", int'(irq), 0);
        wr(0, 0);
        repeat (3) @(negedge clk);

        // sweep over polarity, prescale, reload, match and deadband
        for (int pol = 0; pol < 2; pol++)
            for (int sel = 0; sel < 3; sel++)
                for (int r = 1; r <= 5; r++)
                    for (int m = 0; m <= 6; m++)
                        for (int di = 0; di < 3; di++) begin
                            int dv;
                            dv = (di == 0) ? 0 : ((di == 1) ? 2 : 5);
                            run_cfg(pol[0], sel, r, m, dv,
                                    2 * r * (1 << sel) + dv + 3, 1'b0, "sweep");
                        end

        // R2: run-time writes are ignored
        run_cfg(1'b0, 0, 6, 3, 1, 30, 1'b1, "R2 locked");
        run_cfg(1'b1, 1, 5, 2, 2, 40, 1'b1, "R2 locked");

        // R11: deadband write of 200 clamps to 128
        run_cfg(1'b0, 0, 400, 100, 200, 850, 1'b0, "R11 clamp");
        // R10: long deadband swallows short pulses
        run_cfg(1'b1, 0, 20, 15, 128, 80, 1'b0, "R10 cancel");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule